// File: doc/BRIEF.md
# Clock output gating and frequency-code controller

This block sits between the clock sources of a system clock generator and its output pads. It receives the CPU, SDRAM, PCI, 48 MHz and 24 MHz clocks that are already running. It decides, output by output, whether each clock toggles or is held low. Three things decide this: a per-output enable bit in the configuration bytes, two active-low asynchronous stop inputs, and the free-running status of one output in each group. A configuration bit turns off the pad drivers for every output together.

Each gating request is carried into the domain of the clock it controls through a short synchroniser. A hold flop on the falling edge of that clock then applies it. An output therefore starts and stops only while its source is low, and every high pulse it gives is a full source high phase.

The block also produces the 4-bit frequency code for the synthesiser and the two spread-spectrum mode bits. The frequency code comes either from strap pins, captured in inverted form while the power-on reset is held, or from four non-adjacent bits of the function byte. A second strap chooses whether the shared 24/48 MHz output carries 48 MHz or 24 MHz.

Top module: `clk_out_gate`

## Requirements
- R1: While `pci_stop_n` is low, `pci_clk[6:0]` stay low. `pci_clk_free` is not affected by that pin.
- R2: While `clk_stop_n` is low, `cpu_clk[2:0]` and `sdram_clk[7:0]` stay low. `cpu_clk_free` and `sdram_clk_free` keep toggling.
- R3: An output whose enable bit is 0 stays low. The enable bits are:
  - `cfg_cpu_en[6]` for `cpu_clk_free`, `cfg_cpu_en[3]` for `sdram_clk_free`, and `cfg_cpu_en[2:0]` for `cpu_clk[2:0]`.
  - `cfg_pci_en[7]` for `pci_clk_free` and `cfg_pci_en[6:0]` for `pci_clk[6:0]`.
  - `cfg_sdram_en[3:0]` for `sdram_clk[7:4]`.
  - `sdram_clk[3:0]` have no enable bit.
- R4: `out_oe` is 0 (all outputs released to high impedance) exactly when `cfg_func[0]` is 1.
- R5: When `cfg_func[3]` is 0, `freq_code` is the bitwise inverse of `fs_pin` as captured at reset. When `cfg_func[3]` is 1, `freq_code` is {`cfg_func[2]`, `cfg_func[6]`, `cfg_func[5]`, `cfg_func[4]`}, with bit 2 as the MSB.
- R6: `spread_en` follows `cfg_func[1]`. `spread_down` follows `cfg_func[7]`: 0 selects centre spread and 1 selects down spread.
- R7: `clk_48` always follows `clk48_src`. `clk_24_48` follows `clk48_src` when the strap `sel24_pin_n` was low at reset, and follows `clk24_src` when it was high.
- R8: The straps are captured while `rst_n` is low and are held from its rising edge onward. Later changes on `fs_pin` or `sel24_pin_n` have no effect.
- R9: Every high pulse on a gated output lasts exactly one full high phase of its source. No shortened pulse appears when the output is stopped or restarted.
- R10: A change of a stop pin or an enable bit is visible on the output from the `SYNC_STAGES`+1-th rising source edge after the change onward.
- R11: While `rst_n` is low, all CPU, SDRAM and PCI outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on reset, active low; straps are captured while it is low |
| cpu_src | input | 1 | CPU clock from the synthesiser |
| sdram_src | input | 1 | SDRAM clock source |
| pci_src | input | 1 | PCI clock source |
| clk48_src | input | 1 | 48 MHz source |
| clk24_src | input | 1 | 24 MHz source |
| pci_stop_n | input | 1 | Asynchronous stop for the stoppable PCI outputs, active low |
| clk_stop_n | input | 1 | Asynchronous stop for the stoppable CPU and SDRAM outputs, active low |
| fs_pin | input | 4 | Frequency-select straps |
| sel24_pin_n | input | 1 | 24/48 select strap; low selects 48 MHz |
| cfg_func | input | 8 | Function byte: tristate, spread, frequency source and frequency code |
| cfg_cpu_en | input | 8 | CPU and free-running SDRAM enables |
| cfg_pci_en | input | 8 | PCI enables |
| cfg_sdram_en | input | 8 | Enables for the upper SDRAM outputs |
| cpu_clk | output | 3 | Stoppable CPU clocks |
| cpu_clk_free | output | 1 | Free-running CPU clock |
| sdram_clk | output | 8 | Stoppable SDRAM clocks |
| sdram_clk_free | output | 1 | Free-running SDRAM clock |
| pci_clk | output | 7 | Stoppable PCI clocks |
| pci_clk_free | output | 1 | Free-running PCI clock |
| clk_48 | output | 1 | Fixed 48 MHz output |
| clk_24_48 | output | 1 | Strap-selected 24 or 48 MHz output |
| out_oe | output | 1 | Pad output enable for all clocks |
| freq_code | output | 4 | Active frequency code |
| spread_en | output | 1 | Spread-spectrum enable |
| spread_down | output | 1 | Spread mode: 0 centre, 1 down |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. With that depth, a few source periods of settling are enough for every enable and stop change to reach the outputs. This makes it practical to sweep all 256 values of an enable seed under all four stop-pin combinations, checking every output in both the high and the low phase of its source.

All 256 function bytes are swept against four different strap captures. All 32 strap combinations are applied through repeated resets. Pulse-width monitors on one stoppable CPU output and one stoppable PCI output catch any shortened pulse during the many stop and restart transitions.

// File: rtl/clk_out_gate.sv
`timescale 1ns/1ps
module clk_out_gate #(
  parameter int SYNC_STAGES = 2
)(
  input  logic       rst_n,
  input  logic       cpu_src,
  input  logic       sdram_src,
  input  logic       pci_src,
  input  logic       clk48_src,
  input  logic       clk24_src,
  input  logic       pci_stop_n,
  input  logic       clk_stop_n,
  input  logic [3:0] fs_pin,
  input  logic       sel24_pin_n,
  input  logic [7:0] cfg_func,
  input  logic [7:0] cfg_cpu_en,
  input  logic [7:0] cfg_pci_en,
  input  logic [7:0] cfg_sdram_en,
  output logic [2:0] cpu_clk,
  output logic       cpu_clk_free,
  output logic [7:0] sdram_clk,
  output logic       sdram_clk_free,
  output logic [6:0] pci_clk,
  output logic       pci_clk_free,
  output logic       clk_48,
  output logic       clk_24_48,
  output logic       out_oe,
  output logic [3:0] freq_code,
  output logic       spread_en,
  output logic       spread_down
);
  localparam int NCPU = 3;
  localparam int NSD  = 8;
  localparam int NPCI = 7;
  localparam int NSD_FIXED = NSD - 4;
  localparam int WCPU = NCPU + 1;
  localparam int WSD  = NSD + 1;
  localparam int WPCI = NPCI + 1;

  logic unused_cfg;
  assign unused_cfg = ^{cfg_cpu_en[7], cfg_cpu_en[5:4], cfg_sdram_en[7:4]};

  // straps: transparent while reset is held, frozen from its release
  logic [3:0] fs_lat;
  logic       sel_lat;
  always_latch begin
    if (!rst_n) begin
      fs_lat  <= ~fs_pin;
      sel_lat <= sel24_pin_n;
    end
  end

  logic [WCPU-1:0] cpu_req;
  logic [WSD-1:0]  sd_req;
  logic [WPCI-1:0] pci_req;
  assign cpu_req = {cfg_cpu_en[6], cfg_cpu_en[NCPU-1:0] & {NCPU{clk_stop_n}}};
  assign sd_req  = {cfg_cpu_en[3], cfg_sdram_en[3:0] & {4{clk_stop_n}}, {NSD_FIXED{clk_stop_n}}};
  assign pci_req = {cfg_pci_en[7], cfg_pci_en[NPCI-1:0] & {NPCI{pci_stop_n}}};

  logic [SYNC_STAGES-1:0][WCPU-1:0] cpu_sy;
  logic [SYNC_STAGES-1:0][WSD-1:0]  sd_sy;
  logic [SYNC_STAGES-1:0][WPCI-1:0] pci_sy;
  logic [WCPU-1:0] cpu_g;
  logic [WSD-1:0]  sd_g;
  logic [WPCI-1:0] pci_g;

  always_ff @(posedge cpu_src or negedge rst_n)
    if (!rst_n) cpu_sy <= '0;
    else        cpu_sy <= {cpu_sy[SYNC_STAGES-2:0], cpu_req};
  always_ff @(negedge cpu_src or negedge rst_n)
    if (!rst_n) cpu_g <= '0;
    else        cpu_g <= cpu_sy[SYNC_STAGES-1];

  always_ff @(posedge sdram_src or negedge rst_n)
    if (!rst_n) sd_sy <= '0;
    else        sd_sy <= {sd_sy[SYNC_STAGES-2:0], sd_req};
  always_ff @(negedge sdram_src or negedge rst_n)
    if (!rst_n) sd_g <= '0;
    else        sd_g <= sd_sy[SYNC_STAGES-1];

  always_ff @(posedge pci_src or negedge rst_n)
    if (!rst_n) pci_sy <= '0;
    else        pci_sy <= {pci_sy[SYNC_STAGES-2:0], pci_req};
  always_ff @(negedge pci_src or negedge rst_n)
    if (!rst_n) pci_g <= '0;
    else        pci_g <= pci_sy[SYNC_STAGES-1];

  assign {cpu_clk_free, cpu_clk}     = cpu_g & {WCPU{cpu_src}};
  assign {sdram_clk_free, sdram_clk} = sd_g  & {WSD{sdram_src}};
  assign {pci_clk_free, pci_clk}     = pci_g & {WPCI{pci_src}};

  assign clk_48      = clk48_src;
  assign clk_24_48   = sel_lat ? clk24_src : clk48_src;
  assign out_oe      = ~cfg_func[0];
  assign freq_code   = cfg_func[3] ? {cfg_func[2], cfg_func[6:4]} : fs_lat;
  assign spread_en   = cfg_func[1];
  assign spread_down = cfg_func[7];

  // edge counters since reset, used only to keep $past inside the post-reset window
  logic [2:0] cpu_age, sd_age, pci_age;
  always_ff @(posedge cpu_src or negedge rst_n)
    if (!rst_n) cpu_age <= '0;
    else if (cpu_age != 3'd7) cpu_age <= cpu_age + 3'd1;
  always_ff @(posedge sdram_src or negedge rst_n)
    if (!rst_n) sd_age <= '0;
    else if (sd_age != 3'd7) sd_age <= sd_age + 3'd1;
  always_ff @(posedge pci_src or negedge rst_n)
    if (!rst_n) pci_age <= '0;
    else if (pci_age != 3'd7) pci_age <= pci_age + 3'd1;

  AST_PCI_STOP: assert property (@(posedge pci_src) disable iff (!rst_n)
    (pci_age > 3'(SYNC_STAGES) && !$past(pci_stop_n, SYNC_STAGES)) |-> pci_g[NPCI-1:0] == '0); // R1
  AST_PCI_FREE_RUN: assert property (@(posedge pci_src) disable iff (!rst_n)
    (pci_age > 3'(SYNC_STAGES) && $past(cfg_pci_en[7], SYNC_STAGES)) |-> pci_g[NPCI]); // R1
  AST_CPU_STOP: assert property (@(posedge cpu_src) disable iff (!rst_n)
    (cpu_age > 3'(SYNC_STAGES) && !$past(clk_stop_n, SYNC_STAGES)) |-> cpu_g[NCPU-1:0] == '0); // R2
  AST_CPU_FREE_RUN: assert property (@(posedge cpu_src) disable iff (!rst_n)
    (cpu_age > 3'(SYNC_STAGES) && $past(cfg_cpu_en[6], SYNC_STAGES)) |-> cpu_g[NCPU]); // R2
  AST_SDRAM_STOP: assert property (@(posedge sdram_src) disable iff (!rst_n)
    (sd_age > 3'(SYNC_STAGES) && !$past(clk_stop_n, SYNC_STAGES)) |-> sd_g[NSD-1:0] == '0); // R2
  AST_SDRAM_UPPER_OFF: assert property (@(posedge sdram_src) disable iff (!rst_n)
    (sd_age > 3'(SYNC_STAGES) && !$past(cfg_sdram_en[0], SYNC_STAGES)) |-> !sd_g[NSD_FIXED]); // R3
  AST_STRAP_HELD: assert property (@(posedge cpu_src) disable iff (!rst_n)
    rst_n |=> $stable(fs_lat) && $stable(sel_lat)); // R8
endmodule

// File: tb/clk_out_gate_bench.sv
`timescale 1ns/1ps
module clk_out_gate_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic pci_src = 1'b0;
  initial begin #0.5; forever #6 pci_src = ~pci_src; end
  logic c48 = 1'b0;
  initial begin #0.3; forever #10 c48 = ~c48; end
  logic c24 = 1'b0;
  initial begin #0.7; forever #20 c24 = ~c24; end

  logic       rst_n = 1'b0;
  logic       pci_stop_n = 1'b1, clk_stop_n = 1'b1;
  logic [3:0] fs_pin = '0;
  logic       sel24_pin_n = 1'b0;
  logic [7:0] cfg_func = '0, cfg_cpu_en = '1, cfg_pci_en = '1, cfg_sdram_en = '1;
  logic [2:0] cpu_clk;
  logic       cpu_clk_free, sdram_clk_free, pci_clk_free, clk_48, clk_24_48, out_oe, spread_en, spread_down;
  logic [7:0] sdram_clk;
  logic [6:0] pci_clk;
  logic [3:0] freq_code;

  clk_out_gate #(.SYNC_STAGES(2)) u_clk_out_gate (
    .rst_n(rst_n), .cpu_src(clk), .sdram_src(clk), .pci_src(pci_src),
    .clk48_src(c48), .clk24_src(c24), .pci_stop_n(pci_stop_n), .clk_stop_n(clk_stop_n),
    .fs_pin(fs_pin), .sel24_pin_n(sel24_pin_n), .cfg_func(cfg_func), .cfg_cpu_en(cfg_cpu_en),
    .cfg_pci_en(cfg_pci_en), .cfg_sdram_en(cfg_sdram_en), .cpu_clk(cpu_clk),
    .cpu_clk_free(cpu_clk_free), .sdram_clk(sdram_clk), .sdram_clk_free(sdram_clk_free),
    .pci_clk(pci_clk), .pci_clk_free(pci_clk_free), .clk_48(clk_48), .clk_24_48(clk_24_48),
    .out_oe(out_oe), .freq_code(freq_code), .spread_en(spread_en), .spread_down(spread_down));

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9: every pulse on a gated output is one full source high phase
  realtime t_cpu = 0.0, t_pci = 0.0;
  always @(posedge cpu_clk[0]) t_cpu = $realtime;
  always @(negedge cpu_clk[0]) if (rst_n) chk("R9 cpu pulse width ps", 32'(int'(($realtime - t_cpu) * 1000.0)), 32'd2000);
  always @(posedge pci_clk[0]) t_pci = $realtime;
  always @(negedge pci_clk[0]) if (rst_n) chk("R9 pci pulse width ps", 32'(int'(($realtime - t_pci) * 1000.0)), 32'd6000);

  task automatic check_clocks();
    logic [3:0] e_cpu;
    logic [8:0] e_sd;
    logic [7:0] e_pci;
    e_cpu = {cfg_cpu_en[6], cfg_cpu_en[2:0] & {3{clk_stop_n}}};
    e_sd  = {cfg_cpu_en[3], cfg_sdram_en[3:0] & {4{clk_stop_n}}, {4{clk_stop_n}}};
    e_pci = {cfg_pci_en[7], cfg_pci_en[6:0] & {7{pci_stop_n}}};
    // R10: settle well past SYNC_STAGES+1 edges of the slowest domain
    repeat (4) @(posedge pci_src);
    @(posedge clk); #1;
    chk("R2 R3 cpu high phase", 32'({cpu_clk_free, cpu_clk}), 32'(e_cpu));
    chk("R2 R3 sdram high phase", 32'({sdram_clk_free, sdram_clk}), 32'(e_sd));
    @(negedge clk); #1;
    chk("R9 cpu sdram low phase", 32'({cpu_clk_free, cpu_clk, sdram_clk_free, sdram_clk}), 32'd0);
    @(posedge pci_src); #3;
    chk("R1 R3 pci high phase", 32'({pci_clk_free, pci_clk}), 32'(e_pci));
    @(negedge pci_src); #3;
    chk("R9 pci low phase", 32'({pci_clk_free, pci_clk}), 32'd0);
  endtask

  initial begin
    #700000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 32; p++) begin
      rst_n = 1'b0;
      fs_pin = p[3:0];
      sel24_pin_n = p[4];
      cfg_func = 8'h00;
      #21;
      chk("R11 outputs low in reset",
          32'({cpu_clk_free, cpu_clk, sdram_clk_free, sdram_clk, pci_clk_free, pci_clk}), 32'd0);
      rst_n = 1'b1;
      #2;
      fs_pin = ~p[3:0];
      sel24_pin_n = ~p[4];
      #10;
      chk("R5 R8 latched inverted straps", 32'(freq_code), 32'(~p[3:0] & 4'hF));
      for (int k = 0; k < 12; k++) begin
        #7;
        chk("R7 24/48 output", 32'(clk_24_48), 32'(p[4] ? c24 : c48));
        chk("R7 fixed 48 output", 32'(clk_48), 32'(c48));
      end
      if (p % 8 == 0) begin
        for (int v = 0; v < 256; v++) begin
          cfg_func = v[7:0];
          #1;
          chk("R5 frequency code", 32'(freq_code),
              32'(v[3] ? {v[2], v[6], v[5], v[4]} : ~p[3:0] & 4'hF));
          chk("R6 spread bits", 32'({spread_down, spread_en}), 32'({v[7], v[1]}));
          chk("R4 output enable", 32'(out_oe), 32'(~v[0] & 1'b1));
        end
        cfg_func = 8'h00;
      end
    end
    @(posedge clk); #1;
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 256; e++) begin
        logic [7:0] b;
        b = e[7:0];
        pci_stop_n   = s[0];
        clk_stop_n   = s[1];
        cfg_pci_en   = b;
        cfg_cpu_en   = {b[1], b[6], b[5], b[4], b[0], b[3:1]} ^ 8'h5A;
        cfg_sdram_en = {~b[3:0], b[7:4]};
        check_clocks();
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule